// File: doc/BRIEF.md
# Bidirectional Row-Scan Shift Register

This block is the row-scan path of a display column/row driver when it works as a row (common) driver. It holds one bit per output channel in a chain of stages. Each falling edge of a slow shift clock moves the chain by one stage. A direction input decides which end pin feeds the chain and which end pin passes the bit on. Several devices can be chained in this way to scan a tall panel. The whole chain is exposed in parallel so that the output latch can pick up the selected row.

The shift clock is treated as a data input to the system clock domain. It goes through a synchronizer, and its falling edge is detected there. Each end pin is modelled as a separate input, output and output-enable triple, not as a true tristate pad. A mode input tells the block when the device works as a column driver. In that mode the chain keeps its contents and both end pins stop driving. Reset is asynchronous and active-low, and its release is synchronized to the system clock.

Top module: `row_scan_shifter`

## Requirements
- R1: While reset is asserted, and after reset until the first shift, every stage reads 0.
- R2: With `col_mode` = 0 and `dir_rev` = 0, each shift loads `end_a_in` into stage 1 (bit 0) and moves stage n-1 into stage n. `end_b_in` has no effect.
- R3: With `col_mode` = 0 and `dir_rev` = 1, each shift loads `end_b_in` into the last stage (bit NUM_STAGES-1) and moves stage n+1 into stage n. `end_a_in` has no effect.
- R4: A shift happens only when `shift_clk` is sampled high on one rising `clk` edge and low on the next one (edge k). With the default two sync stages, `stages` takes the new value at rising edge k+2. Steady levels and rising edges of `shift_clk` never shift. Direction, mode and serial input are taken at edge k+2.
- R5: While `col_mode` = 1, falling edges of `shift_clk` leave `stages` unchanged.
- R6: `end_b_oe` is 1 exactly when `col_mode` = 0 and `dir_rev` = 0. `end_a_oe` is 1 exactly when `col_mode` = 0 and `dir_rev` = 1. The two enables are never 1 together.
- R7: An enabled end output carries the stage at its end of the chain: `end_b_out` carries the last stage and `end_a_out` carries stage 1. An end output that is not enabled reads 0.
- R8: Stage n is bit n-1 of `stages`, so channel order runs from bit 0 upward when `dir_rev` = 0 and from the top bit downward when `dir_rev` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| shift_clk | input | 1 | Scan shift clock; falling edge moves the chain |
| col_mode | input | 1 | 1 = column-driver mode (chain frozen, ends idle) |
| dir_rev | input | 1 | 0 = scan from end A to end B, 1 = from end B to end A |
| end_a_in | input | 1 | End A serial input (used when dir_rev = 0) |
| end_a_out | output | 1 | End A serial output (stage 1) |
| end_a_oe | output | 1 | End A drive enable |
| end_b_in | input | 1 | End B serial input (used when dir_rev = 1) |
| end_b_out | output | 1 | End B serial output (last stage) |
| end_b_oe | output | 1 | End B drive enable |
| stages | output | NUM_STAGES | Parallel chain contents, bit n-1 = stage n |

## Verification
Two events can land on the same clock edge: a detected shift edge, and a change of direction or mode. The bench provokes this by flipping `dir_rev` or `col_mode` on the falling clock edge just before the rising edge that performs the shift. The behavioural model applies the setting present at that rising edge. The chain contents and both end pins must match the model on that cycle. The pin on the end that is not the input is toggled freely all the time, so any leak from it would show as a mismatch.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  typedef enum logic {
    SCAN_A_TO_B = 1'b0,
    SCAN_B_TO_A = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/rsr_reset_sync.sv
module rsr_reset_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[DEPTH-2:0], 1'b1};
  end

  assign srst_n = chain_q[DEPTH-1];
endmodule

// File: rtl/rsr_fall_detect.sv
module rsr_fall_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic srst_n,
  input  logic async_in,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/rsr_stage_chain.sv
module rsr_stage_chain
  import row_scan_pkg::*;
#(
  parameter int NUM_STAGES = 80
) (
  input  logic                  clk,
  input  logic                  srst_n,
  input  logic                  step_en,
  input  scan_dir_e             dir,
  input  logic                  ser_a,
  input  logic                  ser_b,
  output logic [NUM_STAGES-1:0] q
);
  localparam int TOP = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] fwd_d;
  logic [NUM_STAGES-1:0] rev_d;
  logic [NUM_STAGES-1:0] q_nxt;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_low_end
      assign fwd_d[i] = ser_a;
    end else begin : g_low_mid
      assign fwd_d[i] = q[i-1];
    end
    if (i == TOP) begin : g_high_end
      assign rev_d[i] = ser_b;
    end else begin : g_high_mid
      assign rev_d[i] = q[i+1];
    end
  end

  always_comb begin
    q_nxt = q;
    if (step_en) begin
      q_nxt = (dir == SCAN_B_TO_A) ? rev_d : fwd_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) q <= '0;
    else         q <= q_nxt;
  end
endmodule

// File: rtl/rsr_end_pins.sv
module rsr_end_pins
  import row_scan_pkg::*;
#(
  parameter int NUM_STAGES = 80
) (
  input  logic                  col_mode,
  input  scan_dir_e             dir,
  input  logic [NUM_STAGES-1:0] q,
  output logic                  a_out,
  output logic                  a_oe,
  output logic                  b_out,
  output logic                  b_oe
);
  always_comb begin
    a_oe  = ~col_mode & (dir == SCAN_B_TO_A);
    b_oe  = ~col_mode & (dir == SCAN_A_TO_B);
    a_out = a_oe & q[0];
    b_out = b_oe & q[NUM_STAGES-1];
  end
endmodule

// File: rtl/row_scan_shifter.sv
module row_scan_shifter
  import row_scan_pkg::*;
#(
  parameter int NUM_STAGES  = 80,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_clk,
  input  logic                  col_mode,
  input  logic                  dir_rev,
  input  logic                  end_a_in,
  output logic                  end_a_out,
  output logic                  end_a_oe,
  input  logic                  end_b_in,
  output logic                  end_b_out,
  output logic                  end_b_oe,
  output logic [NUM_STAGES-1:0] stages
);
  logic      srst_n;
  logic      shift_fall;
  logic      step_en;
  scan_dir_e dir;

  assign dir     = scan_dir_e'(dir_rev);
  assign step_en = shift_fall & ~col_mode;

  rsr_reset_sync #(.DEPTH(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  rsr_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .srst_n   (srst_n),
    .async_in (shift_clk),
    .fall     (shift_fall)
  );

  rsr_stage_chain #(.NUM_STAGES(NUM_STAGES)) u_chain (
    .clk     (clk),
    .srst_n  (srst_n),
    .step_en (step_en),
    .dir     (dir),
    .ser_a   (end_a_in),
    .ser_b   (end_b_in),
    .q       (stages)
  );

  rsr_end_pins #(.NUM_STAGES(NUM_STAGES)) u_pins (
    .col_mode (col_mode),
    .dir      (dir),
    .q        (stages),
    .a_out    (end_a_out),
    .a_oe     (end_a_oe),
    .b_out    (end_b_out),
    .b_oe     (end_b_oe)
  );
endmodule

// File: rtl/row_scan_shifter_chk.sv
module row_scan_shifter_chk #(
  parameter int NUM_STAGES = 80
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  col_mode,
  input logic                  dir_rev,
  input logic                  end_a_out,
  input logic                  end_a_oe,
  input logic                  end_b_out,
  input logic                  end_b_oe,
  input logic [NUM_STAGES-1:0] stages
);
  localparam int TOP = NUM_STAGES - 1;

  // R5: frozen chain in column mode
  a_r5_hold_in_col_mode: assert property (@(posedge clk) disable iff (!rst_n)
    col_mode |=> $stable(stages));

  // R2: forward scan either holds or moves one stage up
  a_r2_forward_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_mode && !dir_rev) |=>
      ($stable(stages) || (stages[TOP:1] == $past(stages[TOP-1:0]))));

  // R3: reverse scan either holds or moves one stage down
  a_r3_reverse_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_mode && dir_rev) |=>
      ($stable(stages) || (stages[TOP-1:0] == $past(stages[TOP:1]))));

  // R6: at most one end drives, none in column mode
  a_r6_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({end_a_oe, end_b_oe}) <= 1);

  a_r6_idle_in_col_mode: assert property (@(posedge clk) disable iff (!rst_n)
    col_mode |-> (!end_a_oe && !end_b_oe));

  // R7: enabled end reflects its end stage
  a_r7_b_end_value: assert property (@(posedge clk) disable iff (!rst_n)
    end_b_oe |-> (end_b_out == stages[TOP]));

  a_r7_a_end_value: assert property (@(posedge clk) disable iff (!rst_n)
    end_a_oe |-> (end_a_out == stages[0]));
endmodule

bind row_scan_shifter row_scan_shifter_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .col_mode  (col_mode),
  .dir_rev   (dir_rev),
  .end_a_out (end_a_out),
  .end_a_oe  (end_a_oe),
  .end_b_out (end_b_out),
  .end_b_oe  (end_b_oe),
  .stages    (stages)
);

// File: tb/row_scan_shifter_tb_top.sv
module row_scan_shifter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 80;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         shift_clk;
  logic         col_mode;
  logic         dir_rev;
  logic         end_a_in;
  logic         end_b_in;
  logic         end_a_out, end_a_oe, end_b_out, end_b_oe;
  logic [N-1:0] stages;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_scan_shifter #(.NUM_STAGES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .col_mode(col_mode),
    .dir_rev(dir_rev), .end_a_in(end_a_in), .end_a_out(end_a_out),
    .end_a_oe(end_a_oe), .end_b_in(end_b_in), .end_b_out(end_b_out),
    .end_b_oe(end_b_oe), .stages(stages)
  );

  // behavioural reference model
  logic [N-1:0] model;
  bit           samp_q[$];

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %s expected %s", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model = '0;
      samp_q.delete();
    end else begin
      if (samp_q.size() >= 3 && samp_q[samp_q.size()-3] == 1'b1 &&
          samp_q[samp_q.size()-2] == 1'b0 && !col_mode) begin
        if (dir_rev) model = {end_b_in, model[N-1:1]};
        else         model = {model[N-2:0], end_a_in};
      end
      samp_q.push_back(shift_clk);
      if (samp_q.size() > 8) void'(samp_q.pop_front());
    end
    #(CLK_PERIOD/4);
    if (!done) begin
      begin
        string tag;
        bit exp_aoe, exp_boe, exp_aout, exp_bout;
        if (!rst_n)        tag = "R1";
        else if (col_mode) tag = "R5";
        else if (dir_rev)  tag = "R3,R4";
        else               tag = "R2,R4";
        check(stages == model, tag, $sformatf("%h", stages), $sformatf("%h", model));
        exp_aoe  = rst_n ? (!col_mode && dir_rev)  : end_a_oe;
        exp_boe  = rst_n ? (!col_mode && !dir_rev) : end_b_oe;
        exp_aout = exp_aoe & model[0];
        exp_bout = exp_boe & model[N-1];
        check({end_a_oe, end_b_oe} == {exp_aoe, exp_boe}, "R6",
              $sformatf("%b%b", end_a_oe, end_b_oe), $sformatf("%b%b", exp_aoe, exp_boe));
        check({end_a_out, end_b_out} == {exp_aout, exp_bout}, "R7",
              $sformatf("%b%b", end_a_out, end_b_out), $sformatf("%b%b", exp_aout, exp_bout));
      end
    end
  end

  // unused end toggles every falling clock edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dir_rev) end_a_in <= $urandom_range(0, 1);
      else         end_b_in <= $urandom_range(0, 1);
    end
  end

  task automatic pulse(input bit din, input bit flip_dir, input bit flip_mode);
    @(negedge clk);
    if (dir_rev) end_b_in = din; else end_a_in = din;
    shift_clk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (flip_dir) begin
      dir_rev = ~dir_rev;
      if (dir_rev) end_b_in = din; else end_a_in = din;
    end
    if (flip_mode) col_mode = ~col_mode;
    @(negedge clk);
    @(negedge clk);
    shift_clk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; shift_clk = 1'b1; col_mode = 1'b0; dir_rev = 1'b0;
    end_a_in = 1'b0; end_b_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R8: single one enters stage 1 (bit 0)
    pulse(1'b1, 1'b0, 1'b0);
    check(stages == {{(N-1){1'b0}}, 1'b1}, "R8", $sformatf("%h", stages), "bit0 only");

    // R2: forward scan with a walking one then random data
    for (int i = 0; i < N + 5; i++) pulse(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 120; i++) pulse(1'($urandom_range(0, 1)), 1'b0, 1'b0);

    // R3: reverse scan
    @(negedge clk); dir_rev = 1'b1;
    pulse(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 120; i++) pulse(1'($urandom_range(0, 1)), 1'b0, 1'b0);

    // R5: column mode freezes the chain
    @(negedge clk); col_mode = 1'b1;
    for (int i = 0; i < 20; i++) pulse(1'($urandom_range(0, 1)), 1'b0, 1'b0);
    @(negedge clk); col_mode = 1'b0;

    // coincident direction / mode change on the shift edge
    for (int i = 0; i < 40; i++) pulse(1'($urandom_range(0, 1)), 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) pulse(1'($urandom_range(0, 1)), 1'b0, 1'b1);
    @(negedge clk); col_mode = 1'b0;

    // R4: steady low shift_clk gives one shift only
    @(negedge clk); shift_clk = 1'b0;
    repeat (20) @(negedge clk);
    shift_clk = 1'b1;
    repeat (10) @(negedge clk);

    // R1: reset mid-run clears
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(stages == '0, "R1", $sformatf("%h", stages), "0");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule